// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page translations so that a memory access does not need a page-table read first. It has two parallel arrays of the same depth. A tag array holds virtual page numbers with a valid bit for each entry. A data array holds the physical page number that belongs to each tag, at the same index.

A lookup is combinational. The requested virtual page number is compared against every valid tag at once. Each entry raises its own match line, and that line selects the data word placed on the physical page output. The hit output is raised when any match line is set.

Translations are installed through a one-clock fill port. If the filled virtual page number is already cached, the fill overwrites that entry in place. Otherwise the fill goes to the entry named by a round-robin victim pointer, and the pointer then advances. A synchronous invalidate-all input empties the cache. The block has no state machine: the only sequential state is the valid vector, the two arrays and the victim pointer.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and the victim pointer is at entry 0.
- R2: When a valid entry holds the requested virtual page number, `lk_hit` is 1 and `lk_ppn` carries that entry's physical page number in the same cycle, with no clock edge in between.
- R3: When no valid entry matches, `lk_hit` is 0 and `lk_ppn` is all zeros.
- R4: A fill with `fill_en` high writes the virtual page number and the physical page number into one entry at a single rising edge, and the entry is valid from the next cycle on.
- R5: A fill of a virtual page number that is not cached goes to the victim entry. The pointer then advances by one and wraps from ENTRIES-1 to 0, so the oldest placement is evicted first.
- R6: A fill of a virtual page number that is already cached and valid overwrites that entry's physical page number. The victim pointer does not move.
- R7: With `inv_all` high and no fill, every entry becomes invalid at the rising edge and all later lookups miss. The victim pointer keeps its value.
- R8: When `inv_all` and a fill fall in the same cycle, only the entry written by that fill is valid afterwards.
- R9: A lookup in the same cycle as a fill or an invalidate sees the contents from before that edge.
- R10: No two valid entries ever hold the same virtual page number, so at most one match line is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup found a valid match |
| lk_ppn | output | PPN_W | Translated physical page number, zero on a miss |
| fill_en | input | 1 | Install a translation at this edge |
| fill_vpn | input | VPN_W | Virtual page number to install |
| fill_ppn | input | PPN_W | Physical page number to install |
| inv_all | input | 1 | Invalidate every entry at this edge |

## Verification
The case that needs the most care is a fill and an invalidate-all landing on the same edge. The fill must survive the clear while every other entry is dropped, and whether a duplicate fill still overwrites in place must not disturb the pointer. The bench provokes this both directly and through random streams in which `inv_all` is sometimes raised alongside `fill_en`, drawing virtual page numbers from a small pool so that duplicates are frequent. A bench model scores each case by checking which page numbers still hit, and with which physical page number, on the cycles that follow. In every cycle the bench also performs a lookup alongside the fill or invalidate, which checks that the lookup returns the contents from before the edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int TLB_ENTRIES_DEF = 8;
    localparam int TLB_VPN_W_DEF   = 20;
    localparam int TLB_PPN_W_DEF   = 16;

    // how the target of a fill was chosen
    typedef enum logic [1:0] {
        FILL_NONE    = 2'd0,
        FILL_REWRITE = 2'd1,
        FILL_VICTIM  = 2'd2
    } fill_kind_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [VPN_W-1:0]   fl_vpn,
    input  logic [ENTRIES-1:0] wr_sel,
    input  logic               inv_all,
    output logic [ENTRIES-1:0] lk_match,
    output logic [ENTRIES-1:0] fl_match,
    output logic [ENTRIES-1:0] valid
);
    logic [VPN_W-1:0] tag_q [ENTRIES];

    // valid vector: a clear still keeps the entry written at the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (inv_all) begin
            valid <= wr_sel;
        end else begin
            valid <= valid | wr_sel;
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[i] <= '0;
            end else if (wr_sel[i]) begin
                tag_q[i] <= fl_vpn;
            end
        end
        // two compare ports: one for translation, one for duplicate detection
        assign lk_match[i] = valid[i] && (tag_q[i] == lk_vpn);
        assign fl_match[i] = valid[i] && (tag_q[i] == fl_vpn);
    end
endmodule

// File: rtl/tlb_ram.sv
module tlb_ram #(
    parameter int ENTRIES = 8,
    parameter int PPN_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] wr_sel,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic [ENTRIES-1:0] rd_sel,
    output logic [PPN_W-1:0]   rd_ppn
);
    logic [PPN_W-1:0] word_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[i] <= '0;
            end else if (wr_sel[i]) begin
                word_q[i] <= wr_ppn;
            end
        end
    end

    // one-hot word select: AND-OR read, zero when no line is set
    always_comb begin
        rd_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            rd_ppn = rd_ppn | (word_q[i] & {PPN_W{rd_sel[i]}});
        end
    end
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic [ENTRIES-1:0] fl_match,
    output logic [ENTRIES-1:0] wr_sel,
    output logic [IDX_W-1:0]   ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    fill_kind_e kind;

    always_comb begin
        unique case ({fill_en, |fl_match})
            2'b11:   kind = FILL_REWRITE;
            2'b10:   kind = FILL_VICTIM;
            default: kind = FILL_NONE;
        endcase
    end

    always_comb begin
        unique case (kind)
            FILL_REWRITE: wr_sel = fl_match;
            FILL_VICTIM:  wr_sel = ENTRIES'(1) << ptr;
            default:      wr_sel = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (kind == FILL_VICTIM) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = TLB_ENTRIES_DEF,
    parameter int VPN_W   = TLB_VPN_W_DEF,
    parameter int PPN_W   = TLB_PPN_W_DEF,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             inv_all
);
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic [ENTRIES-1:0] valid;
    logic [ENTRIES-1:0] wr_sel;
    logic [IDX_W-1:0]   ptr;

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (lk_vpn),
        .fl_vpn   (fill_vpn),
        .wr_sel   (wr_sel),
        .inv_all  (inv_all),
        .lk_match (lk_match),
        .fl_match (fl_match),
        .valid    (valid)
    );

    tlb_ram #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_sel),
        .wr_ppn (fill_ppn),
        .rd_sel (lk_match),
        .rd_ppn (lk_ppn)
    );

    tlb_repl #(.ENTRIES(ENTRIES)) u_repl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_en),
        .fl_match (fl_match),
        .wr_sel   (wr_sel),
        .ptr      (ptr)
    );

    assign lk_hit = |lk_match;
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int ENTRIES = 8,
    parameter int PPN_W   = 16,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fill_en,
    input logic               inv_all,
    input logic               lk_hit,
    input logic [PPN_W-1:0]   lk_ppn,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] fl_match,
    input logic [ENTRIES-1:0] valid,
    input logic [IDX_W-1:0]   ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    assert_hit_one_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> $countones(lk_match) == 1);

    assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_ppn == '0);

    assert_fill_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid != '0);

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fl_match == '0) |=>
            ptr == (($past(ptr) == LAST) ? IDX_W'(0) : IDX_W'($past(ptr) + 1'b1)));

    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en || fl_match != '0) |=> $stable(ptr));

    assert_inv_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !fill_en) |=> valid == '0);

    assert_inv_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && fill_en) |=> $countones(valid) == 1);
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_en  (fill_en),
    .inv_all  (inv_all),
    .lk_hit   (lk_hit),
    .lk_ppn   (lk_ppn),
    .lk_match (lk_match),
    .fl_match (fl_match),
    .valid    (valid),
    .ptr      (ptr)
);

// File: tb/tlb_fa_bench.sv
`timescale 1ns/1ps
module tlb_fa_bench;
    localparam int N  = 8;
    localparam int VW = 20;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [VW-1:0] lk_vpn;
    logic          lk_hit;
    logic [PW-1:0] lk_ppn;
    logic          fill_en;
    logic [VW-1:0] fill_vpn;
    logic [PW-1:0] fill_ppn;
    logic          inv_all;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench model of the cache contents
    logic [VW-1:0] m_vpn [N];
    logic [PW-1:0] m_ppn [N];
    logic [N-1:0]  m_val;
    int            m_ptr;

    always #4 clk = ~clk;

    tlb_fa #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) u_tlb_fa (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (lk_vpn),
        .lk_hit   (lk_hit),
        .lk_ppn   (lk_ppn),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn),
        .inv_all  (inv_all)
    );

    function automatic void model_look(input logic [VW-1:0] v, output logic h, output logic [PW-1:0] p);
        h = 1'b0;
        p = '0;
        for (int i = 0; i < N; i++) begin
            if (m_val[i] && m_vpn[i] == v) begin
                h = 1'b1;
                p = m_ppn[i];
            end
        end
    endfunction

    function automatic void model_edge(input logic fe, input logic [VW-1:0] fv,
                                       input logic [PW-1:0] fp, input logic inv);
        int tgt;
        tgt = -1;
        if (fe) begin
            for (int i = 0; i < N; i++)
                if (m_val[i] && m_vpn[i] == fv) tgt = i;
            if (tgt < 0) begin
                tgt = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
        end
        if (inv) m_val = '0;
        if (tgt >= 0) begin
            m_vpn[tgt] = fv;
            m_ppn[tgt] = fp;
            m_val[tgt] = 1'b1;
        end
    endfunction

    task automatic check_now(input logic [VW-1:0] v, input string tag);
        logic          eh;
        logic [PW-1:0] ep;
        lk_vpn = v;
        #1;
        model_look(v, eh, ep);
        n_cmp++;
        if (lk_hit !== eh || lk_ppn !== ep) begin
            n_fail++;
            $display("FAIL %s vpn=%h: hit=%b ppn=%h expected hit=%b ppn=%h",
                     tag, v, lk_hit, lk_ppn, eh, ep);
        end
    endtask

    // one clock: drive fill/invalidate, look up lv against pre-edge contents
    task automatic op(input logic fe, input logic [VW-1:0] fv, input logic [PW-1:0] fp,
                      input logic inv, input logic [VW-1:0] lv, input string tag);
        @(negedge clk);
        fill_en  = fe;
        fill_vpn = fv;
        fill_ppn = fp;
        inv_all  = inv;
        check_now(lv, tag);
        @(posedge clk);
        model_edge(fe, fv, fp, inv);
    endtask

    task automatic look(input logic [VW-1:0] v, input string tag);
        @(negedge clk);
        fill_en = 1'b0;
        inv_all = 1'b0;
        check_now(v, tag);
    endtask

    task automatic expect_fixed(input logic [VW-1:0] v, input logic eh,
                                input logic [PW-1:0] ep, input string tag);
        @(negedge clk);
        fill_en = 1'b0;
        inv_all = 1'b0;
        lk_vpn  = v;
        #1;
        n_cmp++;
        if (lk_hit !== eh || lk_ppn !== ep) begin
            n_fail++;
            $display("FAIL %s vpn=%h: hit=%b ppn=%h expected hit=%b ppn=%h",
                     tag, v, lk_hit, lk_ppn, eh, ep);
        end
    endtask

    function automatic logic [VW-1:0] pool_vpn();
        return VW'(32'h00100 + ($urandom % 12));
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; lk_vpn = '0; fill_en = 1'b0; fill_vpn = '0; fill_ppn = '0; inv_all = 1'b0;
        m_val = '0; m_ptr = 0;
        for (int i = 0; i < N; i++) begin m_vpn[i] = '0; m_ppn[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset, tag 0 must not hit on reset-cleared storage
        expect_fixed(20'h00000, 1'b0, 16'h0000, "R1");
        expect_fixed(20'h00123, 1'b0, 16'h0000, "R1");

        // R4/R5: fill every entry with distinct pages, pointer walks 0..N-1
        for (int i = 0; i < N; i++)
            op(1'b1, VW'(20'h0A000 + i), PW'(16'hB000 + i), 1'b0, 20'h0A000, "R4");
        for (int i = 0; i < N; i++) look(VW'(20'h0A000 + i), "R2");
        expect_fixed(20'h0A003, 1'b1, 16'hB003, "R2");
        expect_fixed(20'h0FFFF, 1'b0, 16'h0000, "R3");

        // R5: ninth distinct fill wraps to entry 0 and evicts the first page
        op(1'b1, 20'h0C000, 16'hC0C0, 1'b0, 20'h0A000, "R9");
        expect_fixed(20'h0A000, 1'b0, 16'h0000, "R5");
        expect_fixed(20'h0C000, 1'b1, 16'hC0C0, "R5");

        // R6: refill of a cached page rewrites in place, pointer stays at 1
        op(1'b1, 20'h0A005, 16'h5555, 1'b0, 20'h0A005, "R9");
        expect_fixed(20'h0A005, 1'b1, 16'h5555, "R6");
        op(1'b1, 20'h0C001, 16'hC1C1, 1'b0, 20'h0A001, "R9");
        expect_fixed(20'h0A001, 1'b0, 16'h0000, "R6");
        expect_fixed(20'h0A002, 1'b1, 16'hB002, "R6");

        // R7: invalidate-all; lookup in the same cycle still hits (R9)
        op(1'b0, '0, '0, 1'b1, 20'h0A002, "R9");
        expect_fixed(20'h0A002, 1'b0, 16'h0000, "R7");
        expect_fixed(20'h0C000, 1'b0, 16'h0000, "R7");
        // pointer kept at 2 through the clear
        op(1'b1, 20'h0D000, 16'hD000, 1'b0, 20'h0D000, "R7");
        op(1'b1, 20'h0D000, 16'hD001, 1'b0, 20'h0D000, "R6");
        expect_fixed(20'h0D000, 1'b1, 16'hD001, "R6");

        // R8: fill and invalidate on one edge keep only the filled page
        for (int i = 0; i < 4; i++)
            op(1'b1, VW'(20'h0E000 + i), PW'(16'hE000 + i), 1'b0, 20'h0E000, "R9");
        op(1'b1, 20'h0E001, 16'h7777, 1'b1, 20'h0E001, "R9");
        expect_fixed(20'h0E001, 1'b1, 16'h7777, "R8");
        expect_fixed(20'h0E000, 1'b0, 16'h0000, "R8");
        expect_fixed(20'h0D000, 1'b0, 16'h0000, "R8");
        op(1'b1, 20'h0F000, 16'hF00F, 1'b1, 20'h0F000, "R8");
        expect_fixed(20'h0F000, 1'b1, 16'hF00F, "R8");
        expect_fixed(20'h0E001, 1'b0, 16'h0000, "R8");

        // random mix over a small page pool: duplicates, wraps, clears
        for (int k = 0; k < 3000; k++) begin
            logic fe, inv;
            fe  = ($urandom % 100) < 55;
            inv = ($urandom % 100) < 4;
            op(fe, pool_vpn(), PW'($urandom), inv, pool_vpn(), "R9");
            if ((k % 7) == 0) look(pool_vpn(), "R10");
        end
        for (int i = 0; i < 12; i++) look(VW'(20'h00100 + i), "R2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule